// File: doc/BRIEF.md
# Synthesizer Divider Chain with Test Multiplexer

This block holds the digital dividers of a frequency synthesizer. A reference prescaler divides the crystal clock by eight to feed the phase comparator. A loop counter divides the oscillator clock by a programmable 9-bit value to close the loop. A post-divider scales the oscillator clock by 1, 2, 4 or 8 for the main output, and every ratio keeps a 50% duty cycle. A test multiplexer with a registered output brings one internal node out on a test pin.

All the clocks of the synthesizer reach the block as levels and are oversampled by a fast system clock `clk_i`. Each source passes through a two-flop synchronizer and an edge detector, so every divider is an enable-driven counter in a single clock domain. One test code replaces the oscillator clock with the slow serial clock as the source of both the loop counter and the post-divider, so the whole chain can be stepped from the configuration port. While the parallel-load strobe is low, the test register is held and shows the most significant test bit. The divide settings `m_i`, `n_i` and `t_i` come from the configuration loader.

Top module: `synth_div_chain`

## Requirements
- R1: `ref_o` is the crystal clock divided by 8, with a period of 8 crystal periods and a high time of 4 crystal periods.
- R2: For a loop value M of 2 or more, `mcnt_o` has a period of M counter-source periods and stays high for exactly one counter-source period.
- R3: If M is 0, `mcnt_o` is held low. If M is 1, `mcnt_o` is held high.
- R4: The `n_i` codes 00, 01, 10 and 11 set the `fout_o` period to 1, 2, 4 and 8 counter-source periods, and the high time is half the period in each case.
- R5: The test code 110 makes the serial clock the counter source for both the loop counter and the post-divider, and `test_o` then follows `mcnt_o`.
- R6: When the parallel-load strobe is high, `test_o` shows the following node for each code: 000 constant low, 001 `ref_o`, 010 `mcnt_o`, 011 `fout_o` divided by 4 (50% duty), 100 constant high, 101 `fout_o`, 111 constant high.
- R7: While `pload_ni` is low, `test_o` equals `t_i[2]` one `clk_i` cycle later, whatever the selected node is doing.
- R8: While `rst_ni` is low, all four outputs are low.
- R9: With `n_i`=00 outside test mode, `fout_o` repeats `vco_i` three `clk_i` rising edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Oversampling system clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| xtal_i | input | 1 | Crystal reference clock level |
| vco_i | input | 1 | Oscillator clock level |
| sclk_i | input | 1 | Serial configuration clock level |
| pload_ni | input | 1 | Parallel-load strobe; low holds the test register |
| m_i | input | 9 | Loop counter divide value |
| n_i | input | 2 | Post-divider ratio code |
| t_i | input | 3 | Test multiplexer select code |
| ref_o | output | 1 | Reference divided by 8 |
| mcnt_o | output | 1 | Loop counter output |
| fout_o | output | 1 | Post-divided main clock |
| test_o | output | 1 | Registered test node |

## Verification
The strobe override of the test register and the switch of the counter source to the serial clock can act in the same cycle, because both depend on `t_i` and both affect outputs at once. The bench selects the serial-clock test code while holding `pload_ni` low. It checks that `test_o` stays at the value of `t_i[2]` for the whole window. In that same setting it measures the `fout_o` period against the serial clock half-period, and it then releases the strobe and checks that `test_o` returns to following the loop counter.

// File: rtl/synth_div_pkg.sv
package synth_div_pkg;
  localparam int M_W      = 9;
  localparam int N_W      = 2;
  localparam int T_W      = 3;
  localparam int REF_LOG2 = 3;
  localparam int SYNC_STAGES = 2;

  typedef enum logic [T_W-1:0] {
    TS_LOW   = 3'd0,
    TS_REF   = 3'd1,
    TS_MCNT  = 3'd2,
    TS_FDIV4 = 3'd3,
    TS_HIGH  = 3'd4,
    TS_FOUT  = 3'd5,
    TS_SCAN  = 3'd6,
    TS_HIGH2 = 3'd7
  } test_sel_e;
endpackage

// File: rtl/sync_rise.sv
module sync_rise #(
  parameter int STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic d_i,
  output logic lvl_o,
  output logic rise_o
);
  logic [STAGES-1:0] sq;
  logic              prev_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq     <= '0;
      prev_q <= 1'b0;
    end else begin
      sq[0] <= d_i;
      for (int i = 1; i < STAGES; i++) sq[i] <= sq[i-1];
      prev_q <= sq[STAGES-1];
    end
  end

  assign lvl_o  = sq[STAGES-1];
  assign rise_o = sq[STAGES-1] & ~prev_q;
endmodule

// File: rtl/pow2_prescaler.sv
module pow2_prescaler #(
  parameter int W = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         en_i,
  output logic [W-1:0] cnt_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   cnt_o <= '0;
    else if (en_i) cnt_o <= cnt_o + 1'b1;
  end
endmodule

// File: rtl/loop_counter.sv
module loop_counter #(
  parameter int M_W = 9
) (
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           en_i,
  input  logic [M_W-1:0] m_i,
  output logic           tc_o
);
  logic [M_W-1:0] cnt_q;
  logic [M_W-1:0] last;

  assign last = m_i - 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      tc_o  <= 1'b0;
    end else if (m_i == '0) begin
      // illegal setting: park the counter
      cnt_q <= '0;
      tc_o  <= 1'b0;
    end else if (en_i) begin
      if (cnt_q >= last) begin
        cnt_q <= '0;
        tc_o  <= 1'b1;
      end else begin
        cnt_q <= cnt_q + 1'b1;
        tc_o  <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/test_mux_reg.sv
module test_mux_reg
  import synth_div_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           pload_ni,
  input  logic [T_W-1:0] sel_i,
  input  logic           ref_i,
  input  logic           mcnt_i,
  input  logic           fdiv4_i,
  input  logic           fout_i,
  output logic           test_o
);
  logic node;

  always_comb begin
    unique case (test_sel_e'(sel_i))
      TS_LOW:   node = 1'b0;
      TS_REF:   node = ref_i;
      TS_MCNT:  node = mcnt_i;
      TS_FDIV4: node = fdiv4_i;
      TS_HIGH:  node = 1'b1;
      TS_FOUT:  node = fout_i;
      TS_SCAN:  node = mcnt_i;
      TS_HIGH2: node = 1'b1;
      default:  node = 1'b0;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        test_o <= 1'b0;
    else if (!pload_ni) test_o <= sel_i[T_W-1];
    else                test_o <= node;
  end
endmodule

// File: rtl/synth_div_chain.sv
module synth_div_chain
  import synth_div_pkg::*;
(
  input  logic           clk_i,
  input  logic           rst_ni,
  input  logic           xtal_i,
  input  logic           vco_i,
  input  logic           sclk_i,
  input  logic           pload_ni,
  input  logic [M_W-1:0] m_i,
  input  logic [N_W-1:0] n_i,
  input  logic [T_W-1:0] t_i,
  output logic           ref_o,
  output logic           mcnt_o,
  output logic           fout_o,
  output logic           test_o
);
  localparam int OUT_W  = (1 << N_W) - 1;
  localparam int N_TAPS = OUT_W + 1;

  logic xtal_lvl, xtal_rise;
  logic vco_lvl,  vco_rise;
  logic sclk_lvl, sclk_rise;
  logic scan_mode, src_lvl, src_rise;
  logic [REF_LOG2-1:0] ref_cnt;
  logic [OUT_W-1:0]    out_cnt;
  logic [N_TAPS-1:0]   taps;
  logic                fout_q, fout_prev_q;
  logic [1:0]          f4_cnt;

  sync_rise #(.STAGES(SYNC_STAGES)) i_sync_xtal (
    .clk_i, .rst_ni, .d_i(xtal_i), .lvl_o(xtal_lvl), .rise_o(xtal_rise));
  sync_rise #(.STAGES(SYNC_STAGES)) i_sync_vco (
    .clk_i, .rst_ni, .d_i(vco_i), .lvl_o(vco_lvl), .rise_o(vco_rise));
  sync_rise #(.STAGES(SYNC_STAGES)) i_sync_sclk (
    .clk_i, .rst_ni, .d_i(sclk_i), .lvl_o(sclk_lvl), .rise_o(sclk_rise));

  // test code 110 steps the counters from the serial clock
  assign scan_mode = (t_i == TS_SCAN);
  assign src_lvl   = scan_mode ? sclk_lvl  : vco_lvl;
  assign src_rise  = scan_mode ? sclk_rise : vco_rise;

  pow2_prescaler #(.W(REF_LOG2)) i_ref_div (
    .clk_i, .rst_ni, .en_i(xtal_rise), .cnt_o(ref_cnt));
  assign ref_o = ref_cnt[REF_LOG2-1];

  loop_counter #(.M_W(M_W)) i_loop_cnt (
    .clk_i, .rst_ni, .en_i(src_rise), .m_i(m_i), .tc_o(mcnt_o));

  pow2_prescaler #(.W(OUT_W)) i_out_div (
    .clk_i, .rst_ni, .en_i(src_rise), .cnt_o(out_cnt));

  // tap 0 passes the source, tap k is the source divided by 2^k
  assign taps = {out_cnt, src_lvl};

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fout_q      <= 1'b0;
      fout_prev_q <= 1'b0;
    end else begin
      fout_q      <= taps[n_i];
      fout_prev_q <= fout_q;
    end
  end
  assign fout_o = fout_q;

  pow2_prescaler #(.W(2)) i_fdiv4 (
    .clk_i, .rst_ni, .en_i(fout_q & ~fout_prev_q), .cnt_o(f4_cnt));

  test_mux_reg i_test (
    .clk_i, .rst_ni, .pload_ni, .sel_i(t_i),
    .ref_i(ref_o), .mcnt_i(mcnt_o), .fdiv4_i(f4_cnt[1]), .fout_i(fout_q),
    .test_o(test_o));
endmodule

// File: rtl/synth_div_chain_chk.sv
module synth_div_chain_chk
  import synth_div_pkg::*;
(
  input logic           clk_i,
  input logic           rst_ni,
  input logic           vco_i,
  input logic           pload_ni,
  input logic [M_W-1:0] m_i,
  input logic [N_W-1:0] n_i,
  input logic [T_W-1:0] t_i,
  input logic           ref_o,
  input logic           mcnt_o,
  input logic           fout_o,
  input logic           test_o
);
  logic [1:0] warm_q;
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            warm_q <= '0;
    else if (warm_q != 2'd3) warm_q <= warm_q + 1'b1;
  end

  // R3
  m_zero_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (m_i == '0) |=> !mcnt_o);

  // R7
  pload_t2_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pload_ni |=> (test_o == $past(t_i[2])));

  // R6
  sel_low_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pload_ni && t_i == 3'd0) |=> !test_o);

  // R6
  sel_high_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pload_ni && t_i == 3'd4) |=> test_o);

  // R5
  scan_mcnt_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pload_ni && t_i == 3'd6) |=> (test_o == $past(mcnt_o)));

  // R9
  div1_follow_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (warm_q == 2'd3 && $past(n_i) == 2'd0 && $past(t_i) != 3'd6)
      |-> (fout_o == $past(vco_i, 3)));

  // R8
  always_comb begin
    if (!rst_ni) begin
      reset_quiet_chk: assert (!ref_o && !mcnt_o && !fout_o && !test_o);
    end
  end
endmodule

bind synth_div_chain synth_div_chain_chk i_chk (
  .clk_i, .rst_ni, .vco_i, .pload_ni, .m_i, .n_i, .t_i,
  .ref_o, .mcnt_o, .fout_o, .test_o);

// File: tb/test_synth_div_chain.sv
module test_synth_div_chain;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       xtal = 1'b0, vco = 1'b0, sclk = 1'b0;
  logic       pload_n = 1'b1;
  logic [8:0] m = 9'd5;
  logic [1:0] n = 2'd0;
  logic [2:0] t = 3'd0;
  logic       ref_w, mcnt_w, fout_w, test_w;

  int  vectors = 0, misses = 0;
  int  vh = 2, xh = 3, sh = 5;
  bit  vco_man = 1'b0;

  always #2.5 clk = ~clk;

  synth_div_chain i_synth_div_chain (
    .clk_i(clk), .rst_ni(rst_n), .xtal_i(xtal), .vco_i(vco), .sclk_i(sclk),
    .pload_ni(pload_n), .m_i(m), .n_i(n), .t_i(t),
    .ref_o(ref_w), .mcnt_o(mcnt_w), .fout_o(fout_w), .test_o(test_w));

  // source clock generators
  initial begin
    int cv = 0, cx = 0, cs = 0;
    forever begin
      @(negedge clk);
      if (!vco_man) begin
        cv++;
        if (cv >= vh) begin vco = ~vco; cv = 0; end
      end
      cx++;
      if (cx >= xh) begin xtal = ~xtal; cx = 0; end
      cs++;
      if (cs >= sh) begin sclk = ~sclk; cs = 0; end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    vectors++;
    if (!ok) begin
      misses++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic logic get(input int sel);
    case (sel)
      0: return fout_w;
      1: return mcnt_w;
      2: return ref_w;
      default: return test_w;
    endcase
  endfunction

  task automatic measure(input int sel, output int per, output int hi);
    int  guard = 0;
    logic cur, prev;
    per = -1; hi = -1;
    @(negedge clk);
    while (get(sel) !== 1'b0 && guard < 5000) begin @(negedge clk); guard++; end
    while (get(sel) !== 1'b1 && guard < 5000) begin @(negedge clk); guard++; end
    if (guard >= 5000) return;
    per = 0; hi = 0; cur = 1'b1; prev = 1'b1;
    do begin
      if (cur) hi++;
      per++;
      @(negedge clk);
      prev = cur;
      cur  = get(sel);
      guard++;
    end while (!(cur && !prev) && guard < 5000);
    if (guard >= 5000) begin per = -1; hi = -1; end
  endtask

  task automatic hold(input int sel, input logic val, input int cycles, output int bad);
    bad = 0;
    for (int i = 0; i < cycles; i++) begin
      @(negedge clk);
      if (get(sel) !== val) bad++;
    end
  endtask

  task automatic check_clock(input int sel, input int settle, input int eper,
                             input int ehi, input string req);
    int p, h;
    repeat (settle) @(negedge clk);
    measure(sel, p, h);
    chk(p == eper, req, p, eper);
    chk(h == ehi, req, h, ehi);
  endtask

  task automatic t_reset;
    repeat (6) @(negedge clk);
    // R8 outputs quiet in reset while sources toggle
    chk({ref_w, mcnt_w, fout_w, test_w} == 4'b0, "R8", {ref_w, mcnt_w, fout_w, test_w}, 0);
    rst_n = 1'b1;
  endtask

  task automatic t_ref;
    // R1 crystal half period 3 -> period 48, high 24
    check_clock(2, 20, 8 * 2 * xh, 4 * 2 * xh, "R1");
  endtask

  task automatic t_outdiv;
    t = 3'd0;
    for (int k = 0; k < 4; k++) begin
      n = k[1:0];
      // R4 ratio 2^k, 50% duty
      check_clock(0, 80, (2 * vh) << k, vh << k, "R4");
    end
  endtask

  task automatic t_div1_latency;
    int cnt = 0;
    n = 2'd0; t = 3'd0;
    @(posedge clk); #1;
    vco_man = 1'b1; vco = 1'b0;
    repeat (6) @(posedge clk);
    #1 vco = 1'b1;
    do begin
      @(posedge clk); #1;
      cnt++;
    end while (fout_w !== 1'b1 && cnt < 10);
    // R9 three rising edges of latency
    chk(cnt == 3, "R9", cnt, 3);
    vco_man = 1'b0;
  endtask

  task automatic t_mcnt;
    t = 3'd0;
    m = 9'd5;
    // R2
    check_clock(1, 60, 5 * 2 * vh, 2 * vh, "R2");
    m = 9'd511;
    check_clock(1, 2100, 511 * 2 * vh, 2 * vh, "R2");
  endtask

  task automatic t_mdeg;
    int bad;
    m = 9'd0;
    repeat (4) @(negedge clk);
    hold(1, 1'b0, 100, bad);
    chk(bad == 0, "R3 M=0", bad, 0);
    m = 9'd1;
    repeat (20) @(negedge clk);
    hold(1, 1'b1, 100, bad);
    chk(bad == 0, "R3 M=1", bad, 0);
  endtask

  task automatic t_mux;
    int bad;
    m = 9'd5; n = 2'd1;
    t = 3'd0; repeat (4) @(negedge clk);
    hold(3, 1'b0, 60, bad); chk(bad == 0, "R6 code 000", bad, 0);
    t = 3'd4; repeat (4) @(negedge clk);
    hold(3, 1'b1, 60, bad); chk(bad == 0, "R6 code 100", bad, 0);
    t = 3'd7; repeat (4) @(negedge clk);
    hold(3, 1'b1, 60, bad); chk(bad == 0, "R6 code 111", bad, 0);
    t = 3'd1; check_clock(3, 20, 16 * xh, 8 * xh, "R6 code 001");
    t = 3'd2; check_clock(3, 60, 10 * vh, 2 * vh, "R6 code 010");
    t = 3'd3; check_clock(3, 60, 16 * vh, 8 * vh, "R6 code 011");
    n = 2'd2;
    t = 3'd5; check_clock(3, 60, 8 * vh, 4 * vh, "R6 code 101");
  endtask

  task automatic t_scan;
    m = 9'd3; n = 2'd1; t = 3'd6;
    // R5 serial clock half period 5 drives both counters
    check_clock(3, 120, 3 * 2 * sh, 2 * sh, "R5 test");
    check_clock(0, 20, 2 * 2 * sh, 2 * sh, "R5 fout");
  endtask

  task automatic t_pload_overlap;
    int bad;
    m = 9'd3; n = 2'd1; t = 3'd6;
    pload_n = 1'b0;
    repeat (3) @(negedge clk);
    // R7 strobe wins while the serial clock drives the chain
    hold(3, 1'b1, 80, bad); chk(bad == 0, "R7 code 110", bad, 0);
    check_clock(0, 0, 4 * sh, 2 * sh, "R5 fout under strobe");
    t = 3'd3;
    repeat (3) @(negedge clk);
    hold(3, 1'b0, 80, bad); chk(bad == 0, "R7 code 011", bad, 0);
    t = 3'd6;
    pload_n = 1'b1;
    check_clock(3, 60, 6 * sh, 2 * sh, "R7 release");
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    misses++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    t_reset();
    t_ref();
    t_outdiv();
    t_div1_latency();
    t_mcnt();
    t_mdeg();
    t_mux();
    t_scan();
    t_pload_overlap();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end
endmodule